// File: doc/BRIEF.md
# Active Pin-Loop Tamper Checker

This block guards a physical wire loop. One output pin leaves the chip and comes back on one or more input pins, which arrive already synchronized. While enabled, the block periodically drives a fresh pseudo-random level onto the output. It waits a programmable number of cycles for the level to travel around the loop and through the synchronizers. It then compares every returning input with the level it drove.

A check in which any input disagrees counts as one mismatch. Once the number of mismatches reaches a programmable threshold, a sticky tamper flag is raised toward the response logic. The flag stays up until a clear pulse. A cut, shorted or externally forced wire cannot follow the changing pattern, so it is caught. A pin tied to a fixed level is caught as well.

An internal 16-bit LFSR supplies the pattern in place of a true random source.

Top module: `pinloop_checker`

## Requirements
- R1: In the cycle after a cycle with rst high, loop_out_o and tamper_o are both 0. The LFSR is loaded with 16'hACE1.
- R2: While en_i is high, an interval counter starts at 0 in the first enabled cycle and rises by one per cycle. A tick occurs in each cycle where the counter is greater than or equal to interval_i, and the counter then returns to 0. At the edge that ends a tick cycle, the LFSR shifts left with new bit 0 = s[15]^s[13]^s[12]^s[10], and loop_out_o takes that new bit 0. At all other times loop_out_o holds its value.
- R3: The first cycle in which the new level is on loop_out_o is called C. The inputs are compared in cycle C+settle_i against loop_out_o. A check where any bit of loop_in_i differs from loop_out_o is one mismatch, however many bits differ. A loop that returns the level within settle_i cycles never raises the flag.
- R4: Each mismatch adds one to a counter. tamper_o goes high at the edge that ends the mismatch cycle in which the counter reaches thresh_i. A thresh_i of 0 behaves as 1.
- R5: The mismatch counter saturates at the threshold. Once high, tamper_o stays high through further mismatches and through disable, until a clear.
- R6: clear_i high zeroes the mismatch counter and tamper_o at the next edge. A mismatch in the same cycle as clear_i is discarded.
- R7: While en_i is low, loop_out_o is 0 from the next cycle, no comparison is made, any pending check is dropped, and the mismatch counter is 0. After re-enabling, a full thresh_i mismatches are needed to raise the flag.
- R8: A tick that arrives while a check is still waiting restarts the wait with settle_i. The earlier check is lost, unless its compare cycle is that same cycle. If interval_i is smaller than settle_i, no comparison is ever made.
- R9: The LFSR neither advances nor reseeds while disabled. After re-enabling, the pattern continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables the loop checking |
| interval_i | input | INTV_W | Tick period minus one, in cycles |
| settle_i | input | SETTLE_W | Wait from output change to input compare, in cycles |
| thresh_i | input | THR_W | Mismatches needed to raise the flag (0 acts as 1) |
| clear_i | input | 1 | Clears the mismatch counter and the flag |
| loop_in_i | input | NUM_IN | Synchronized returning loop inputs |
| loop_out_o | output | 1 | Driven loop level |
| tamper_o | output | 1 | Sticky tamper flag |

## Verification
Two functions can fall in the same cycle: a clear pulse and a compare that finds a mismatch. The bench uses its own model to predict the exact cycle of the next failing compare. It raises clear_i in that cycle, with one input forced inverted and a threshold of two. It then judges that the flag stays low after that compare and after the following one, and rises only at the second mismatch after the clear. A second pairing is also run: a tick landing in the very cycle a check compares, with interval_i equal to settle_i. There the old check must still count, and the flag rises.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1, shift-left form
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pl_timer.sv
module pl_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] interval,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q >= interval);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pl_lfsr.sv
module pl_lfsr
  import pl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic adv,
  output logic drive_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_n;
  logic              drive_q;

  assign state_n = lfsr_step(state_q);
  assign drive_o = drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LFSR_SEED;
      drive_q <= 1'b0;
    end else if (!en) begin
      drive_q <= 1'b0;
    end else if (adv) begin
      state_q <= state_n;
      drive_q <= state_n[0];
    end
  end
endmodule

// File: rtl/pl_sampler.sv
module pl_sampler #(
  parameter int NUM_IN = 2,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [DW-1:0]     settle,
  input  logic [NUM_IN-1:0] loop_in,
  input  logic              drive,
  output logic              mism,
  output logic              pend_o
);
  logic          pend_q;
  logic [DW-1:0] wait_q;
  logic          cmp;

  assign cmp    = en && pend_q && (wait_q == '0);
  assign mism   = cmp && (loop_in != {NUM_IN{drive}});
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else if (tick) begin
      pend_q <= 1'b1;
      wait_q <= settle;
    end else if (pend_q) begin
      if (wait_q == '0) pend_q <= 1'b0;
      else              wait_q <= wait_q - 1'b1;
    end
  end
endmodule

// File: rtl/pl_mcount.sv
module pl_mcount #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clear,
  input  logic          mism,
  input  logic [TW-1:0] thresh,
  output logic [TW-1:0] cnt_o,
  output logic          flag_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] thr_eff;
  logic [TW-1:0] cnt_inc;
  logic          flag_q;

  assign thr_eff = (thresh == '0) ? TW'(1) : thresh;
  assign cnt_inc = (cnt_q < thr_eff) ? cnt_q + 1'b1 : cnt_q;
  assign cnt_o   = cnt_q;
  assign flag_o  = flag_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (mism) begin
      cnt_q <= cnt_inc;
      if (cnt_inc >= thr_eff) flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pinloop_checker.sv
module pinloop_checker #(
  parameter int NUM_IN   = 2,
  parameter int INTV_W   = 16,
  parameter int SETTLE_W = 8,
  parameter int THR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [INTV_W-1:0]   interval_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [THR_W-1:0]    thresh_i,
  input  logic                clear_i,
  input  logic [NUM_IN-1:0]   loop_in_i,
  output logic                loop_out_o,
  output logic                tamper_o
);
  logic             tick_w;
  logic             drive_w;
  logic             mism_w;
  logic             pend_w;
  logic [THR_W-1:0] cnt_w;

  pl_timer #(.W(INTV_W)) u_timer (
    .clk(clk), .rst(rst), .en(en_i), .interval(interval_i), .tick(tick_w)
  );

  pl_lfsr u_lfsr (
    .clk(clk), .rst(rst), .en(en_i), .adv(tick_w), .drive_o(drive_w)
  );

  pl_sampler #(.NUM_IN(NUM_IN), .DW(SETTLE_W)) u_samp (
    .clk(clk), .rst(rst), .en(en_i), .tick(tick_w), .settle(settle_i),
    .loop_in(loop_in_i), .drive(drive_w), .mism(mism_w), .pend_o(pend_w)
  );

  pl_mcount #(.TW(THR_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_i), .clear(clear_i), .mism(mism_w),
    .thresh(thresh_i), .cnt_o(cnt_w), .flag_o(tamper_o)
  );

  assign loop_out_o = drive_w;
endmodule

// File: rtl/pinloop_checker_sva.sv
module pinloop_checker_sva #(
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             clear_i,
  input logic             loop_out_o,
  input logic             tamper_o,
  input logic             tick,
  input logic             pend,
  input logic             mism,
  input logic [THR_W-1:0] cnt
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!loop_out_o && !tamper_o)); // R1
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst) (en_i && !tick) |=> $stable(loop_out_o)); // R2
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(tamper_o) |-> $past(mism)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (tamper_o && !clear_i) |=> tamper_o); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) clear_i |=> (!tamper_o && cnt == '0)); // R6
  AST_DIS_OUT_LOW: assert property (@(posedge clk) disable iff (rst) !en_i |=> (!loop_out_o && !pend && cnt == '0)); // R7
endmodule

bind pinloop_checker pinloop_checker_sva #(.THR_W(THR_W)) u_sva (
  .clk(clk), .rst(rst), .en_i(en_i), .clear_i(clear_i),
  .loop_out_o(loop_out_o), .tamper_o(tamper_o), .tick(tick_w),
  .pend(pend_w), .mism(mism_w), .cnt(cnt_w)
);

// File: tb/tb_pinloop_checker.sv
`timescale 1ns/1ps
module tb_pinloop_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [15:0] interval_i = 16'd9;
  logic [7:0]  settle_i = 8'd3;
  logic [7:0]  thresh_i = 8'd3;
  logic        clear_i = 1'b0;
  logic [1:0]  loop_in_i = 2'b00;
  logic        loop_out_o;
  logic        tamper_o;

  pinloop_checker dut (
    .clk(clk), .rst(rst), .en_i(en_i), .interval_i(interval_i),
    .settle_i(settle_i), .thresh_i(thresh_i), .clear_i(clear_i),
    .loop_in_i(loop_in_i), .loop_out_o(loop_out_o), .tamper_o(tamper_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int          m_t;
  logic [15:0] m_lfsr;
  logic        m_out;
  logic        m_pend;
  int          m_s;
  int          m_cnt;
  logic        m_flag;
  bit          last_mis;
  // external loop: two-cycle delay plus fault mask
  logic        d1 = 0, d2 = 0;
  logic [1:0]  mask = 2'b00;
  string       out_tag = "R2";
  string       flag_tag = "R4";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_t = 0; m_lfsr = 16'hACE1; m_out = 0; m_pend = 0; m_s = 0; m_cnt = 0; m_flag = 0;
  endtask

  function automatic bit will_mis();
    return en_i && m_pend && (m_s == 0) && (loop_in_i != {2{m_out}});
  endfunction

  task automatic cyc();
    bit mis;
    bit tk;
    int te;
    mis = will_mis();
    last_mis = mis;
    @(posedge clk);
    #1;
    if (rst) model_reset();
    else begin
      if (!en_i) begin
        m_t = 0; m_out = 0; m_pend = 0; m_s = 0;
      end else begin
        tk = (m_t >= int'(interval_i));
        m_t = tk ? 0 : m_t + 1;
        if (tk) begin
          m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
          m_out = m_lfsr[0]; m_pend = 1; m_s = int'(settle_i);
        end else if (m_pend) begin
          if (m_s == 0) m_pend = 0; else m_s = m_s - 1;
        end
      end
      if (clear_i) begin m_cnt = 0; m_flag = 0; end
      else if (!en_i) m_cnt = 0;
      else if (mis) begin
        te = (thresh_i == 0) ? 1 : int'(thresh_i);
        if (m_cnt < te) m_cnt = m_cnt + 1;
        if (m_cnt >= te) m_flag = 1;
      end
    end
    chk(loop_out_o == m_out, out_tag, loop_out_o, m_out);
    chk(tamper_o == m_flag, flag_tag, tamper_o, m_flag);
    d2 = d1; d1 = loop_out_o;
    loop_in_i = {2{d2}} ^ mask;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // run until the given number of mismatch compares has taken effect
  task automatic run_mis(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < 2000 && seen < n; i++) begin
      cyc();
      if (last_mis) seen++;
    end
  endtask

  initial begin
    int toggles;
    int seen;
    logic prev;
    model_reset();
    run(3);
    rst = 0;
    cyc();
    chk(loop_out_o == 0, "R1", loop_out_o, 0);
    chk(tamper_o == 0, "R1", tamper_o, 0);

    // clean loop: pattern toggles, never flags
    en_i = 1; flag_tag = "R3";
    toggles = 0; prev = loop_out_o;
    for (int i = 0; i < 300; i++) begin
      cyc();
      if (loop_out_o != prev) toggles++;
      prev = loop_out_o;
    end
    chk(toggles > 5, "R2", toggles, 6);
    chk(tamper_o == 0, "R3", tamper_o, 0);

    // one input inverted: flag after exactly three mismatches
    flag_tag = "R4"; mask = 2'b01;
    seen = 0;
    for (int i = 0; i < 500 && !tamper_o; i++) begin
      cyc();
      if (last_mis) seen++;
    end
    chk(tamper_o == 1, "R4", tamper_o, 1);
    chk(seen == 3, "R4", seen, 3);
    flag_tag = "R5";
    run(80);
    chk(tamper_o == 1, "R5", tamper_o, 1);

    // clear in the same cycle as a mismatch
    flag_tag = "R6"; thresh_i = 2;
    clear_i = 1; cyc(); clear_i = 0;
    chk(tamper_o == 0, "R6", tamper_o, 0);
    for (int i = 0; i < 200 && !will_mis(); i++) cyc();
    clear_i = 1; cyc(); clear_i = 0;
    chk(tamper_o == 0, "R6", tamper_o, 0);
    run_mis(1, seen);
    cyc();
    chk(tamper_o == 0, "R6", tamper_o, 0);
    run_mis(1, seen);
    chk(tamper_o == 1, "R4", tamper_o, 1);

    // disable holds the flag, drives low
    out_tag = "R7"; flag_tag = "R5";
    en_i = 0; run(30);
    chk(loop_out_o == 0, "R7", loop_out_o, 0);
    chk(tamper_o == 1, "R5", tamper_o, 1);
    clear_i = 1; cyc(); clear_i = 0;

    // partial count is dropped by disable
    flag_tag = "R7"; thresh_i = 3; en_i = 1; out_tag = "R9";
    run_mis(2, seen);
    cyc();
    chk(tamper_o == 0, "R7", tamper_o, 0);
    en_i = 0; out_tag = "R7"; run(20);
    en_i = 1; out_tag = "R9";
    seen = 0;
    for (int i = 0; i < 500 && !tamper_o; i++) begin
      cyc();
      if (last_mis) seen++;
    end
    chk(seen == 3, "R7", seen, 3);
    out_tag = "R2";

    // tick faster than the settle wait: never compares
    flag_tag = "R8"; clear_i = 1; cyc(); clear_i = 0;
    interval_i = 2; settle_i = 5; thresh_i = 1;
    run(150);
    chk(tamper_o == 0, "R8", tamper_o, 0);
    // tick landing on the compare cycle: old check still counts
    interval_i = 4; settle_i = 4;
    run(100);
    chk(tamper_o == 1, "R8", tamper_o, 1);

    // threshold zero acts as one
    flag_tag = "R4"; clear_i = 1; cyc(); clear_i = 0;
    interval_i = 7; settle_i = 2; thresh_i = 0;
    run_mis(1, seen);
    chk(tamper_o == 1, "R4", tamper_o, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule